// File: doc/BRIEF.md
# Four-Bit JK-Entry Universal Shift Register

This block is a four-stage synchronous register with two operating modes, chosen by an active-low load select. With the select high, the stages shift one place toward the high end on each rising clock edge. The first stage then takes its new value from a pair of serial inputs: a J input and an inverted-K input. Between them, these inputs can clear, keep, toggle or set that stage. With the select low, a four-bit parallel word is captured into all stages at once, and the serial inputs have no effect.

An active-low master clear empties the register at once, without waiting for the clock, and it overrides every other input. The block drives the four stage values and also a complemented copy of the last stage. Connecting the serial inputs together gives plain D-style serial entry. Shift-left use comes from outside wiring: each output is routed back to the parallel input one place below it, with the load select held low.

Top module: `jk_shift4`

## Requirements
- R1: Stage values change only at a rising edge of `clk` or on master clear. A change on `par_in`, `load_n`, `j_in` or `kb_in` between edges leaves `q` unchanged.
- R2: With `load_n`=1 at a rising edge, `q[1]`, `q[2]` and `q[3]` take the values that `q[0]`, `q[1]` and `q[2]` held before the edge.
- R3: With `load_n`=1, the new `q[0]` depends on the pair (`j_in`,`kb_in`): (0,0) gives 0, (0,1) keeps the old `q[0]`, (1,0) gives the inverse of the old `q[0]`, and (1,1) gives 1.
- R4: With `load_n`=0 at a rising edge, `q[i]` takes `par_in[i]` for i=0..3, and `j_in`/`kb_in` have no effect.
- R5: While `rst_n`=0, `q` is 0000. This holds from the moment `rst_n` falls, without a clock edge, and clock edges with any inputs leave it at 0000.
- R6: `q3_n` is always the complement of `q[3]`.
- R7: After `rst_n` returns to 1, the first change to `q` happens at the next rising edge of `clk` and follows R2 to R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all updates happen on its rising edge |
| rst_n | input | 1 | Asynchronous master clear, active low |
| load_n | input | 1 | Mode select: 0 = parallel load, 1 = shift |
| j_in | input | 1 | Serial J input to stage 0 |
| kb_in | input | 1 | Serial inverted-K input to stage 0 |
| par_in | input | 4 | Parallel data, bit i goes to stage i |
| q | output | 4 | Stage outputs, bit 0 is the serial entry stage |
| q3_n | output | 1 | Complement of stage 3 |

## Verification
On every clock cycle after reset is released, the assertions check the shift of the upper stages, the J/inverted-K rule for stage 0, the parallel capture, the complemented output and the cleared state during master clear. Other behaviours can only be shown by the bench's scenarios. These are: the immediate clear when reset falls between edges, inputs that move between edges without any effect, and the timing of the first update after reset release. The bench loads each of the sixteen states and applies every serial input pair in shift mode from each one, so every entry of the stage-0 rule is reached from both old values.

// File: rtl/jk_shift4.sv
module jk_shift4 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_n,
  input  logic       j_in,
  input  logic       kb_in,
  input  logic [3:0] par_in,
  output logic [3:0] q,
  output logic       q3_n
);
  logic       head_nxt;
  logic [3:0] q_nxt;

  assign head_nxt = (j_in & ~q[0]) | (kb_in & q[0]);
  assign q_nxt    = load_n ? {q[2:0], head_nxt} : par_in;
  assign q3_n     = ~q[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 4'b0000;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/jk_shift4_chk.sv
module jk_shift4_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       load_n,
  input logic       j_in,
  input logic       kb_in,
  input logic [3:0] par_in,
  input logic [3:0] q,
  input logic       q3_n
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assert_shift_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(load_n) |-> q[3:1] == $past(q[2:0]));

  assert_head_rule_R3: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(load_n) |->
      q[0] == (($past(j_in) & ~$past(q[0])) | ($past(kb_in) & $past(q[0]))));

  assert_par_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !$past(load_n) |-> q == $past(par_in));

  assert_clear_hold_R5: assert property (@(posedge clk)
    !rst_n |-> q == 4'b0000);

  assert_tail_inverse_R6: assert property (@(posedge clk)
    q3_n == ~q[3]);
endmodule

bind jk_shift4 jk_shift4_chk u_chk (
  .clk(clk), .rst_n(rst_n), .load_n(load_n), .j_in(j_in),
  .kb_in(kb_in), .par_in(par_in), .q(q), .q3_n(q3_n)
);

// File: tb/test_jk_shift4.sv
`timescale 1ns/1ps
module test_jk_shift4;
  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       load_n = 1'b1;
  logic       j_in = 1'b0;
  logic       kb_in = 1'b0;
  logic [3:0] par_in = 4'h0;
  logic [3:0] q;
  logic       q3_n;

  int checks = 0;
  int errors = 0;
  logic [3:0] model = 4'h0;
  bit done = 0;

  jk_shift4 i_jk_shift4 (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .j_in(j_in),
    .kb_in(kb_in), .par_in(par_in), .q(q), .q3_n(q3_n)
  );

  always #10 clk = ~clk;

  task automatic check(input string req);
    checks++;
    if (q !== model || q3_n !== ~model[3]) begin
      errors++;
      $display("FAIL %s q=%b q3_n=%b expected q=%b q3_n=%b",
               req, q, q3_n, model, ~model[3]);
    end
  endtask

  task automatic step(input logic ld, input logic j, input logic kb,
                      input logic [3:0] p, input string req);
    @(negedge clk);
    load_n = ld; j_in = j; kb_in = kb; par_in = p;
    if (!ld) model = p;
    else begin
      logic h;
      case ({j, kb})
        2'b00: h = 1'b0;
        2'b01: h = model[0];
        2'b10: h = ~model[0];
        default: h = 1'b1;
      endcase
      model = {model[2:0], h};
    end
    @(posedge clk); #5;
    check(req);
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog q=%b expected completion", q);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1 rst_n = 1'b0;
    #2 model = 4'h0; check("R5 reset state");
    @(negedge clk); rst_n = 1'b1;
    // R7: first update on the next edge after release
    step(1'b0, 1'b0, 1'b0, 4'hA, "R7 first edge after release");

    // R4: every parallel word, with every J/K-bar pair ignored
    for (int v = 0; v < 16; v++)
      for (int s = 0; s < 4; s++)
        step(1'b0, s[1], s[0], v[3:0], "R4 parallel load");

    // R2/R3: every start state, every J/K-bar pair, twice in a row
    for (int v = 0; v < 16; v++)
      for (int s = 0; s < 4; s++) begin
        step(1'b0, 1'b0, 1'b0, v[3:0], "R4 preload");
        step(1'b1, s[1], s[0], ~v[3:0], "R2 R3 shift");
        step(1'b1, s[1], s[0], v[3:0], "R2 R3 shift again");
      end

    // D-style entry: J and K-bar tied together
    for (int b = 0; b < 8; b++)
      step(1'b1, b[0] ^ b[2], b[0] ^ b[2], 4'h0, "R3 tied serial entry");

    // R1: inputs change between edges, outputs hold
    step(1'b0, 1'b0, 1'b0, 4'h5, "R4 preload");
    @(negedge clk);
    load_n = 1'b0; par_in = 4'hA; #2 par_in = 4'h3; load_n = 1'b1; j_in = 1'b1; kb_in = 1'b0;
    #2 check("R1 no change between edges");
    load_n = 1'b0; par_in = 4'hC;
    model = 4'hC;
    @(posedge clk); #5 check("R1 update at edge");

    // R5: reset mid-shift, between edges, overrides clocked loads
    step(1'b1, 1'b1, 1'b1, 4'h0, "R2 R3 shift");
    step(1'b1, 1'b1, 1'b0, 4'h0, "R2 R3 shift");
    @(negedge clk); #3;
    rst_n = 1'b0; model = 4'h0;
    #1 check("R5 immediate clear");
    load_n = 1'b0; par_in = 4'hF;
    @(posedge clk); #5 check("R5 clear overrides load");
    load_n = 1'b1; j_in = 1'b1; kb_in = 1'b1;
    @(posedge clk); #5 check("R5 clear overrides shift");
    @(negedge clk); rst_n = 1'b1;
    #3 check("R7 no change at release");
    model = 4'h1;
    @(posedge clk); #5 check("R7 shift after release");
    step(1'b1, 1'b1, 1'b1, 4'h0, "R6 complement after shift");
    step(1'b1, 1'b1, 1'b1, 4'h0, "R6 complement after shift");
    step(1'b1, 1'b0, 1'b0, 4'h0, "R6 complement after shift");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule